// File: doc/BRIEF.md
# NAND Hamming Syndrome Classifier

This block takes the Hamming check code that was stored next to a NAND data chunk, together with the code recomputed after the chunk was read back, and decides what happened to that chunk. The two codes are combined by XOR into a syndrome. The number of set bits in the syndrome, measured against a target count that depends on the chunk mode, selects one of four outcomes. The outcomes are clean, a single data bit that can be corrected, a damaged check code, or an error that cannot be corrected. For a correctable error the block returns the byte (or word) index and the bit index that must be flipped. The caller may also present one data word with its index, and the block flips the indicated bit in that word when the index matches.

Chunks arrive as beats on a valid/ready stream, one beat per chunk, and results leave on a second valid/ready stream one cycle after a beat is accepted. The input accepts a beat only when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). An output beat the consumer does not take stays unchanged. The beats of a multi-chunk page are marked with a last flag on the final chunk. The block keeps a running page verdict: correctable chunks set a sticky flag, and the first fatal chunk fixes the verdict for the rest of that page.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: When the masked syndrome is zero, the result status is 0 (clean) and the byte and bit indices are 0. The indices are also 0 for every status other than 1.
- R2: In chunk mode 0 (256-byte chunks, 3-byte code), a syndrome with exactly 11 set bits gives status 1. The byte index is {syn[10:8], syn[7:3]} and the bit index is syn[2:0].
- R3: In chunk mode 1 (512-byte chunks, 3-byte code), a syndrome with exactly 12 set bits gives status 1. The byte index is {syn[11:8], syn[7:3]} and the bit index is syn[2:0].
- R4: Mode values 2 and 3 both select whole-page mode with 16-bit words and a 4-byte code. A syndrome with exactly 15 set bits gives status 1, with word index {syn[15:8], syn[7:4]} and bit index syn[3:0].
- R5: In every mode, a syndrome with exactly one set bit gives status 2 (check code damaged).
- R6: Any other nonzero set-bit count gives status 3 (uncorrectable). This includes a count that is correct for a different mode.
- R7: In modes 0 and 1, code bits [31:24] of both inputs have no effect on any output.
- R8: The output word equals the input word XOR a one-hot mask at the bit index only when the status is 1 and in_word_idx equals the reported byte index. Otherwise the output word equals the input word unchanged.
- R9: A beat accepted on a clock edge shows out_valid high after that edge. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, every output holds its value.
- R10: out_page_status is the verdict over the chunks of the current page up to and including this one. It is the status of the first chunk with status 2 or 3 if there is one, otherwise 1 if any chunk had status 1, otherwise 0. A new page starts after reset and after every beat accepted with in_last high.
- R11: While reset is asserted and on the first cycle after it is released, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Chunk beat present |
| in_ready | output | 1 | Block accepts the beat this cycle |
| in_mode | input | 2 | 0: 256-byte chunk, 1: 512-byte chunk, 2/3: page of 16-bit words |
| in_code_stored | input | 32 | Check code read from the spare area |
| in_code_calc | input | 32 | Check code recomputed over the read data |
| in_word_idx | input | 12 | Index of the presented data word within the chunk |
| in_word | input | DATA_W | Presented data word |
| in_last | input | 1 | Beat is the final chunk of its page |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_status | output | 2 | 0 clean, 1 corrected single bit, 2 code damaged, 3 uncorrectable |
| out_byte_idx | output | 12 | Byte or word index of the bad bit |
| out_bit_idx | output | 4 | Bit position within that byte or word |
| out_word | output | DATA_W | Presented word, corrected when it is the bad one |
| out_last | output | 1 | Copy of in_last for this beat |
| out_page_status | output | 2 | Running page verdict including this chunk |

## Verification
The hardest situation to reach is a page verdict that has to survive several events at once. In that case a fatal chunk arrives in the middle of a page, and later chunks of the same page are clean, correctable, or fatal with a different code. All of this happens while the consumer stalls the output so that beats are held and re-presented. Directed pages build exactly these orders: a correctable chunk after a damaged one, a second fatal chunk after the first, and a one-chunk page right after a closing beat. A long random phase then mixes zero, one-hot, well-formed single-bit and arbitrary syndromes with random gaps and random back-pressure. Throughout, a behavioural model compares every output on every cycle.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

  localparam int CODE_W = 32;
  localparam int IDX_W  = 12;
  localparam int BIT_W  = 4;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_C256 = 2'd0;
  localparam logic [MODE_W-1:0] MODE_C512 = 2'd1;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_BAD = 2'd2,
    ST_MULTI    = 2'd3
  } syn_status_e;

  function automatic logic is_fatal(syn_status_e s);
    return (s == ST_CODE_BAD) || (s == ST_MULTI);
  endfunction

  // Page verdict update: the first fatal outcome wins, single-bit outcomes are sticky.
  function automatic syn_status_e merge_verdict(syn_status_e acc, syn_status_e cur);
    if (is_fatal(acc))                          return acc;
    if (is_fatal(cur))                          return cur;
    if ((acc == ST_FIXED) || (cur == ST_FIXED)) return ST_FIXED;
    return ST_CLEAN;
  endfunction

endpackage

// File: rtl/syn_popcount.sv
module syn_popcount #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);

  logic [CW-1:0] part [W+1];

  assign part[0] = '0;

  generate
    for (genvar g = 0; g < W; g++) begin : g_acc
      assign part[g+1] = part[g] + CW'(vec[g]);
    end
  endgenerate

  assign ones = part[W];

endmodule

// File: rtl/syn_locate.sv
module syn_locate
  import ecc_syn_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [15:0]       syn_lo,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BIT_W-1:0]  bit_idx
);

  always_comb begin
    case (mode)
      MODE_C256: begin
        byte_idx = {4'b0, syn_lo[10:8], syn_lo[7:3]};
        bit_idx  = {1'b0, syn_lo[2:0]};
      end
      MODE_C512: begin
        byte_idx = {3'b0, syn_lo[11:8], syn_lo[7:3]};
        bit_idx  = {1'b0, syn_lo[2:0]};
      end
      default: begin
        byte_idx = {syn_lo[15:8], syn_lo[7:4]};
        bit_idx  = syn_lo[3:0];
      end
    endcase
  end

endmodule

// File: rtl/syn_classify.sv
module syn_classify
  import ecc_syn_pkg::*;
#(
  parameter int ONES_C256 = 11,
  parameter int ONES_C512 = 12,
  parameter int ONES_PAGE = 15
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output syn_status_e       status,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BIT_W-1:0]  bit_idx
);

  localparam int CW = $clog2(CODE_W + 1);

  logic              three_byte;
  logic [CODE_W-1:0] syn;
  logic [CW-1:0]     ones;
  logic [CW-1:0]     target;
  logic [IDX_W-1:0]  loc_byte;
  logic [BIT_W-1:0]  loc_bit;

  assign three_byte = !mode[1];

  always_comb begin
    syn = code_a ^ code_b;
    if (three_byte) syn[CODE_W-1:24] = '0;
  end

  syn_popcount #(.W(CODE_W)) u_pop (
    .vec  (syn),
    .ones (ones)
  );

  syn_locate u_loc (
    .mode     (mode),
    .syn_lo   (syn[15:0]),
    .byte_idx (loc_byte),
    .bit_idx  (loc_bit)
  );

  always_comb begin
    case (mode)
      MODE_C256: target = CW'(ONES_C256);
      MODE_C512: target = CW'(ONES_C512);
      default:   target = CW'(ONES_PAGE);
    endcase
  end

  always_comb begin
    if (ones == '0)                 status = ST_CLEAN;
    else if (ones == CW'(1))        status = ST_CODE_BAD;
    else if (ones == target)        status = ST_FIXED;
    else                            status = ST_MULTI;
  end

  assign byte_idx = (status == ST_FIXED) ? loc_byte : '0;
  assign bit_idx  = (status == ST_FIXED) ? loc_bit  : '0;

endmodule

// File: rtl/syn_fixer.sv
module syn_fixer
  import ecc_syn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter bit FIX_EN = 1'b1
) (
  input  logic              apply,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);

  generate
    if (FIX_EN) begin : g_fix
      logic [DATA_W-1:0] mask;
      logic              hit;
      assign mask     = DATA_W'(1) << bit_idx;
      assign hit      = apply && (word_idx == byte_idx);
      assign word_out = hit ? (word_in ^ mask) : word_in;
    end else begin : g_pass
      logic unused_fix;
      assign unused_fix = ^{apply, word_idx, byte_idx, bit_idx};
      assign word_out   = word_in;
    end
  endgenerate

endmodule

// File: rtl/syn_page_acc.sv
module syn_page_acc
  import ecc_syn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        last,
  input  syn_status_e cur,
  output syn_status_e verdict
);

  syn_status_e acc_q;

  assign verdict = merge_verdict(acc_q, cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ST_CLEAN;
    end else if (take) begin
      acc_q <= last ? ST_CLEAN : verdict;
    end
  end

endmodule

// File: rtl/ecc_syndrome_checker.sv
module ecc_syndrome_checker
  import ecc_syn_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit FIX_EN    = 1'b1,
  parameter int ONES_C256 = 11,
  parameter int ONES_C512 = 12,
  parameter int ONES_PAGE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [31:0]       in_code_stored,
  input  logic [31:0]       in_code_calc,
  input  logic [11:0]       in_word_idx,
  input  logic [DATA_W-1:0] in_word,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_status,
  output logic [11:0]       out_byte_idx,
  output logic [3:0]        out_bit_idx,
  output logic [DATA_W-1:0] out_word,
  output logic              out_last,
  output logic [1:0]        out_page_status
);

  syn_status_e       c_status;
  logic [IDX_W-1:0]  c_byte;
  logic [BIT_W-1:0]  c_bit;
  logic [DATA_W-1:0] c_word;
  syn_status_e       c_page;
  logic              take;

  logic              vld_q;
  syn_status_e       st_q;
  syn_status_e       page_q;
  logic [IDX_W-1:0]  byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] word_q;
  logic              last_q;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  syn_classify #(
    .ONES_C256 (ONES_C256),
    .ONES_C512 (ONES_C512),
    .ONES_PAGE (ONES_PAGE)
  ) u_cls (
    .mode     (in_mode),
    .code_a   (in_code_stored),
    .code_b   (in_code_calc),
    .status   (c_status),
    .byte_idx (c_byte),
    .bit_idx  (c_bit)
  );

  syn_fixer #(
    .DATA_W (DATA_W),
    .FIX_EN (FIX_EN)
  ) u_fix (
    .apply    (c_status == ST_FIXED),
    .word_idx (in_word_idx),
    .byte_idx (c_byte),
    .bit_idx  (c_bit),
    .word_in  (in_word),
    .word_out (c_word)
  );

  syn_page_acc u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .last    (in_last),
    .cur     (c_status),
    .verdict (c_page)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      st_q   <= ST_CLEAN;
      page_q <= ST_CLEAN;
      byte_q <= '0;
      bit_q  <= '0;
      word_q <= '0;
      last_q <= 1'b0;
    end else if (take) begin
      vld_q  <= 1'b1;
      st_q   <= c_status;
      page_q <= c_page;
      byte_q <= c_byte;
      bit_q  <= c_bit;
      word_q <= c_word;
      last_q <= in_last;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid       = vld_q;
  assign out_status      = st_q;
  assign out_page_status = page_q;
  assign out_byte_idx    = byte_q;
  assign out_bit_idx     = bit_q;
  assign out_word        = word_q;
  assign out_last        = last_q;

endmodule

// File: rtl/ecc_syn_checker.sv
module ecc_syn_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_status,
  input logic [11:0]       out_byte_idx,
  input logic [3:0]        out_bit_idx,
  input logic [DATA_W-1:0] out_word,
  input logic              out_last,
  input logic [1:0]        out_page_status
);

  p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_take_gives_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) && $stable(out_byte_idx)
      && $stable(out_bit_idx) && $stable(out_word) && $stable(out_last)
      && $stable(out_page_status)));

  p_index_zero_unless_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_status != 2'd1)) |-> (out_byte_idx == '0 && out_bit_idx == '0));

  p_fix_touches_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ($countones(out_word ^ $past(in_word)) <= 1));

  p_fatal_sets_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status[1]) |-> out_page_status[1]);

  p_single_marks_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd1) |-> (out_page_status != 2'd0));

endmodule

bind ecc_syndrome_checker ecc_syn_checker #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_word         (in_word),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_status      (out_status),
  .out_byte_idx    (out_byte_idx),
  .out_bit_idx     (out_bit_idx),
  .out_word        (out_word),
  .out_last        (out_last),
  .out_page_status (out_page_status)
);

// File: tb/ecc_syndrome_checker_tb.sv
module ecc_syndrome_checker_tb;

  localparam int DW = 16;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] st;
    logic [31:0] ca;
    logic [11:0] widx;
    logic [15:0] word;
    logic        last;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [31:0] in_code_stored = '0;
  logic [31:0] in_code_calc = '0;
  logic [11:0] in_word_idx = '0;
  logic [DW-1:0] in_word = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_status;
  logic [11:0] out_byte_idx;
  logic [3:0]  out_bit_idx;
  logic [DW-1:0] out_word;
  logic        out_last;
  logic [1:0]  out_page_status;

  ecc_syndrome_checker u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_mode (in_mode),
    .in_code_stored (in_code_stored), .in_code_calc (in_code_calc),
    .in_word_idx (in_word_idx), .in_word (in_word), .in_last (in_last),
    .out_valid (out_valid), .out_ready (out_ready), .out_status (out_status),
    .out_byte_idx (out_byte_idx), .out_bit_idx (out_bit_idx), .out_word (out_word),
    .out_last (out_last), .out_page_status (out_page_status)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cycles = 0;

  beat_t q[$];

  // reference model state
  bit          exp_valid = 0;
  int          exp_status, exp_byte, exp_bit, exp_page, page_acc = 0;
  logic [15:0] exp_word;
  bit          exp_last;
  string       exp_tag = "R1";
  bit          acc_last = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int merge(int a, int c);
    if (a >= 2) return a;
    if (c >= 2) return c;
    if (a == 1 || c == 1) return 1;
    return 0;
  endfunction

  // behavioural classification: status, index, bit, requirement tag
  task automatic ref_eval(input logic [1:0] mode, input logic [31:0] st, input logic [31:0] ca,
                          output int status, output int bidx, output int bit_n, output string tag);
    logic [31:0] syn;
    int n, tgt;
    syn = st ^ ca;
    if (mode < 2) syn = syn & 32'h00FF_FFFF;
    n = $countones(syn);
    tgt = (mode == 0) ? 11 : (mode == 1) ? 12 : 15;
    bidx = 0; bit_n = 0;
    if (n == 0) begin status = 0; tag = "R1"; end
    else if (n == 1) begin status = 2; tag = "R5"; end
    else if (n == tgt) begin
      status = 1;
      if (mode == 0) begin bit_n = syn & 7; bidx = ((syn >> 3) & 31) + (((syn >> 8) & 7) * 32); tag = "R2"; end
      else if (mode == 1) begin bit_n = syn & 7; bidx = ((syn >> 3) & 31) + (((syn >> 8) & 15) * 32); tag = "R3"; end
      else begin bit_n = syn & 15; bidx = ((syn >> 4) & 15) + (((syn >> 8) & 255) * 16); tag = "R4"; end
    end else begin status = 3; tag = "R6"; end
    if (mode < 2 && st[31:24] != ca[31:24]) tag = "R7";
  endtask

  always @(posedge clk) begin
    int s, b, bt;
    string t;
    bit rdy;
    if (!rst_n) begin
      exp_valid = 0; page_acc = 0; acc_last = 0;
    end else begin
      rdy = !exp_valid || out_ready;
      acc_last = in_valid && rdy;
      if (acc_last) begin
        ref_eval(in_mode, in_code_stored, in_code_calc, s, b, bt, t);
        exp_status = s; exp_byte = b; exp_bit = bt; exp_tag = t;
        exp_word = in_word;
        if (s == 1 && int'(in_word_idx) == b) exp_word = in_word ^ (16'(1) << bt);
        exp_last = in_last;
        exp_page = merge(page_acc, s);
        page_acc = in_last ? 0 : exp_page;
        exp_valid = 1;
      end else if (out_ready) begin
        exp_valid = 0;
      end
    end
  end

  task automatic compare();
    check(out_valid == exp_valid, "R9", "out_valid", out_valid, exp_valid);
    check(in_ready == (!exp_valid || out_ready), "R9", "in_ready", in_ready, !exp_valid || out_ready);
    if (exp_valid) begin
      check(int'(out_status) == exp_status, exp_tag, "status", out_status, exp_status);
      check(int'(out_byte_idx) == exp_byte, exp_tag, "byte_idx", out_byte_idx, exp_byte);
      check(int'(out_bit_idx) == exp_bit, exp_tag, "bit_idx", out_bit_idx, exp_bit);
      check(out_word == exp_word, "R8", "word", out_word, exp_word);
      check(out_last == exp_last, "R9", "last", out_last, exp_last);
      check(int'(out_page_status) == exp_page, "R10", "page_status", out_page_status, exp_page);
    end
  endtask

  function automatic logic [31:0] mk_single(logic [1:0] mode, logic [14:0] loc);
    if (mode == 0) return {10'h0, ~loc[10:0], loc[10:0]};
    if (mode == 1) return {8'h0, ~loc[11:0], loc[11:0]};
    return {1'b0, ~loc, 1'b0, loc};
  endfunction

  task automatic add(logic [1:0] mode, logic [31:0] syn, bit match, logic [11:0] widx,
                     logic [15:0] word, bit last);
    beat_t bb;
    int s, b, bt;
    string t;
    bb.mode = mode; bb.st = $urandom; bb.ca = bb.st ^ syn;
    ref_eval(mode, bb.st, bb.ca, s, b, bt, t);
    bb.widx = match ? 12'(b) : widx;
    bb.word = word; bb.last = last;
    q.push_back(bb);
  endtask

  initial begin : watchdog
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    // R11: reset state
    #5;
    check(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);

    // R1 clean
    add(0, 32'h0, 0, 12'h3, 16'hA5A5, 1);
    add(3, 32'h0, 0, 12'h0, 16'h1234, 1);
    // R2 / R3 / R4 single-bit, presented word matches
    add(0, mk_single(0, 15'h05A3), 1, 0, 16'h00F0, 1);
    add(1, mk_single(1, 15'h0ABC), 1, 0, 16'h0055, 1);
    add(2, mk_single(2, 15'h1234), 1, 0, 16'hFFFF, 1);
    add(3, mk_single(3, 15'h7FFF), 1, 0, 16'h0000, 1);
    add(0, mk_single(0, 15'h0000), 1, 0, 16'h0001, 1);
    // R8 single-bit with non-matching word index
    add(1, mk_single(1, 15'h0123), 0, 12'hFFF, 16'h8001, 1);
    // R5 one-hot syndromes, at the edges of each mode
    add(0, 32'h0000_0001, 0, 0, 16'h1111, 1);
    add(1, 32'h0080_0000, 0, 0, 16'h2222, 1);
    add(2, 32'h8000_0000, 0, 0, 16'h3333, 1);
    // R6 wrong counts, including another mode's target
    add(1, mk_single(0, 15'h0155), 0, 0, 16'h4444, 1);
    add(0, mk_single(1, 15'h0155), 0, 0, 16'h5555, 1);
    add(2, 32'h0000_0003, 0, 0, 16'h6666, 1);
    add(0, mk_single(2, 15'h0055), 0, 0, 16'h7777, 1);
    // R7 upper byte garbage in 3-byte modes
    add(0, mk_single(0, 15'h0321) | 32'hFF00_0000, 1, 0, 16'h0F0F, 1);
    add(1, 32'h5A00_0000, 0, 0, 16'h0F0F, 1);
    add(0, 32'h0100_0001, 0, 0, 16'h0F0F, 1);
    // R10 pages: sticky single; fatal followed by later events; one-chunk page
    add(0, mk_single(0, 15'h0011), 0, 0, 16'h0, 0);
    add(0, 32'h0, 0, 0, 16'h0, 0);
    add(0, mk_single(0, 15'h0022), 0, 0, 16'h0, 1);
    add(1, 32'h0, 0, 0, 16'h0, 0);
    add(1, 32'h0000_0100, 0, 0, 16'h0, 0);
    add(1, mk_single(1, 15'h0033), 0, 0, 16'h0, 0);
    add(1, 32'h0000_00FF, 0, 0, 16'h0, 1);
    add(2, 32'h0, 0, 0, 16'h0, 1);
    add(2, 32'h0000_000F, 0, 0, 16'h0, 0);
    add(2, 32'h0001_0000, 0, 0, 16'h0, 1);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [1:0]  m;
      logic [31:0] syn;
      int k;
      m = 2'($urandom);
      k = $urandom % 4;
      case (k)
        0: syn = 32'h0;
        1: syn = 32'h1 << ($urandom % ((m < 2) ? 24 : 32));
        2: syn = mk_single(m, 15'($urandom));
        default: syn = $urandom;
      endcase
      if (m < 2 && ($urandom % 3 == 0)) syn[31:24] = 8'($urandom);
      add(m, syn, ($urandom % 2) == 1, 12'($urandom % 8), 16'($urandom), ($urandom % 4) == 0);
    end

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

    while (q.size() > 0 || in_valid) begin
      @(negedge clk);
      compare();
      if (acc_last) void'(q.pop_front());
      if (in_valid && !acc_last) begin
        // keep presenting the same beat
      end else if (q.size() > 0 && ($urandom % 5 != 0)) begin
        in_valid       = 1'b1;
        in_mode        = q[0].mode;
        in_code_stored = q[0].st;
        in_code_calc   = q[0].ca;
        in_word_idx    = q[0].widx;
        in_word        = q[0].word;
        in_last        = q[0].last;
      end else begin
        in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
    end
    out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk);
      compare();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule